// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences the power modes of a small microcontroller. Firmware selects one of four modes (run, halt, suspend or deep sleep) through a small register port. In each mode the controller drives the system clock gate, the precision oscillator enable, the low-power oscillator enable, the core regulator enable, the RAM supply selector and an active-low wake request output that tells external devices the controller is awake. A power-on reset input clears all state. A separate system reset input clears all state except the flag that records a reset-pin glitch.

Five asynchronous wake-up event inputs and the reset pin pass through two-flop synchronisers. The halt mode ends only on a reset. Suspend and deep sleep end when an enabled event arrives, or when the reset pin falls for too short a time to reset the device. Every wake passes through a six-cycle resume phase with the clocks running. During the first two cycles of that phase the wake flags read as zero. The source-valid output stays low for the whole phase.

The state machine has five states: `PM_ACTIVE` (run), `PM_STOP` (halt), `PM_SUSPEND`, `PM_SLEEP` and `PM_RESUME`. The transitions are:
- `ACTIVE->STOP`, `ACTIVE->SUSPEND` and `ACTIVE->SLEEP`, on a mode write.
- `SUSPEND->RESUME` and `SLEEP->RESUME`, on a wake.
- `RESUME->ACTIVE`, after six cycles.
- `any->ACTIVE`, on either reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: After either reset the outputs are: `sys_clk_en`=1, `prec_osc_en`=1, `core_reg_en`=1, `ram_main_sel`=0, `wake_req_n`=0 and `src_valid`=1. The state code reads 0.
- R2: A write to address 0 while in run mode takes effect in the cycle after the clock edge that samples the write. `wdata[1:0]` selects the mode: 1 is halt, 2 is suspend, 3 is deep sleep and 0 changes nothing. A mode write in any other state is ignored.
- R3: Halt gives `sys_clk_en`=0, `prec_osc_en`=0 and `core_reg_en`=1. Wake events and reset-pin falls do not end halt. Only `rst_n` or `por_n` end it.
- R4: Suspend gives `sys_clk_en`=0, `prec_osc_en`=0, `lp_osc_en`=0, `core_reg_en`=1, `ram_main_sel`=0 and `wake_req_n`=0.
- R5: Deep sleep gives `core_reg_en`=0, `ram_main_sel`=1 and `wake_req_n`=1, with both clocks off. On exit, `wake_req_n` returns to 0.
- R6: The wake event bits are: bit 0 clock oscillator failure, bit 1 clock alarm, bit 2 port match, bit 3 I2C address match and bit 4 capacitive threshold. Enables are written at address 1, bits [4:0]. An enabled event that goes high ends suspend or deep sleep at the third clock edge after it rises. A disabled event has no effect.
- R7: A fall of `rst_pin_n` during suspend or deep sleep ends that mode at the third edge after the fall, and sets flag bit 5.
- R8: Address 2 returns the wake flags: bits [4:0] for the event causes and bit 5 for the reset pin. Flags set at the edge of the wake. Writing 1 to a flag bit at address 2 clears that flag.
- R9: After a wake the controller spends 6 cycles in resume, with the clocks and regulator on and `src_valid`=0, and then enters run. During the first 2 of those cycles, address 2 reads 0.
- R10: `rst_n` clears flag bits [4:0] and keeps bit 5. `por_n` clears all flags.
- R11: The readback mux is: address 0 gives the state code (0 run, 1 halt, 2 suspend, 3 deep sleep, 4 resume), address 1 the enables, address 2 the flags and address 3 the oscillator bit.
- R12: Address 3, bit 0 holds the low-power oscillator setting. `lp_osc_en` follows it in run, halt and resume, and is 0 in suspend and deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the pin-glitch flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 6 | Register write data |
| cfg_rdata | output | 6 | Register read data for `cfg_addr` |
| wake_evt | input | 5 | Asynchronous wake-up event inputs |
| rst_pin_n | input | 1 | Reset pin level, asynchronous |
| sys_clk_en | output | 1 | System clock gate enable |
| prec_osc_en | output | 1 | Precision internal oscillator enable |
| lp_osc_en | output | 1 | Low-power oscillator enable |
| core_reg_en | output | 1 | Core regulator enable |
| ram_main_sel | output | 1 | RAM supply switched to the main supply |
| wake_req_n | output | 1 | Wake request toward external devices, low while awake |
| src_valid | output | 1 | Wake-source indicators are valid |

## Verification
Because the outputs decode directly from the state, a wrong state shows on the enable pins in the cycle after the faulty edge. A resume counter that is off by one moves `src_valid` and the flag unmasking by a cycle. The bench compares against its model every clock, so it catches that within the same wake. A synchroniser with the wrong depth moves the wake edge away from the third clock edge, and the per-cycle comparison of the enables shows this at once. A lost or wrongly cleared flag shows at address 2 on the next read.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int NUM_SRC  = 5;
    localparam int DATA_W   = NUM_SRC + 1;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_WKEN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;
    localparam logic [ADDR_W-1:0] A_OSC   = 2'd3;

    localparam logic [1:0] MC_NONE    = 2'd0;
    localparam logic [1:0] MC_STOP    = 2'd1;
    localparam logic [1:0] MC_SUSPEND = 2'd2;
    localparam logic [1:0] MC_SLEEP   = 2'd3;

    typedef enum logic [2:0] {
        PM_ACTIVE  = 3'd0,
        PM_STOP    = 3'd1,
        PM_SUSPEND = 3'd2,
        PM_SLEEP   = 3'd3,
        PM_RESUME  = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic sys_clk_en;
        logic prec_osc_en;
        logic lp_osc_allow;
        logic core_reg_en;
        logic ram_main_sel;
        logic wake_req_n;
        logic src_valid;
    } pm_ctrl_t;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_wake_flags.sv
module pwr_wake_flags #(
    parameter int NSRC = 5,
    localparam int DW  = NSRC + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            por_ni,
    input  logic            en_we_i,
    input  logic            clr_we_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            set_en_i,
    input  logic [NSRC-1:0] evt_sync_i,
    input  logic            pin_fell_i,
    input  logic            mask_i,
    output logic [NSRC-1:0] en_o,
    output logic [DW-1:0]   flags_vis_o,
    output logic            wake_any_o
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] src_q;
    logic            pin_q;
    logic [NSRC-1:0] hit;
    logic [DW-1:0]   flags_all;

    assign hit        = evt_sync_i & en_q;
    assign wake_any_o = (|hit) | pin_fell_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= wdata_i[NSRC-1:0];
        end
    end

    // Source flags: W1C, a set in the same cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            src_q <= '0;
        end else begin
            src_q <= (src_q & ~(clr_we_i ? wdata_i[NSRC-1:0] : '0))
                   | (set_en_i ? hit : '0);
        end
    end

    // Reset-pin cause flag survives the system reset
    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            pin_q <= 1'b0;
        end else if (rst_ni) begin
            pin_q <= (pin_q & ~(clr_we_i & wdata_i[NSRC]))
                   | (set_en_i & pin_fell_i);
        end
    end

    assign flags_all   = {pin_q, src_q};
    assign en_o        = en_q;
    assign flags_vis_o = mask_i ? '0 : flags_all;

    // R8
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && !set_en_i) |=> ((flags_all & $past(wdata_i)) == '0));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int RESUME_CYC = 6,
    parameter int MASK_CYC   = 2,
    localparam int CW        = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      mode_we_i,
    input  logic [1:0] mode_code_i,
    input  logic      wake_any_i,
    output pm_state_e state_o,
    output logic      lowpwr_o,
    output logic      flag_mask_o,
    output pm_ctrl_t  ctrl_o
);

    localparam logic [CW-1:0] CNT_LAST = CW'(RESUME_CYC - 1);
    localparam logic [CW-1:0] CNT_MASK = CW'(MASK_CYC);

    pm_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (mode_we_i) begin
                    unique case (mode_code_i)
                        MC_STOP:    state_d = PM_STOP;
                        MC_SUSPEND: state_d = PM_SUSPEND;
                        MC_SLEEP:   state_d = PM_SLEEP;
                        default:    state_d = PM_ACTIVE;
                    endcase
                end
            end
            PM_STOP: state_d = PM_STOP;
            PM_SUSPEND, PM_SLEEP: begin
                if (wake_any_i) begin
                    state_d = PM_RESUME;
                    cnt_d   = '0;
                end
            end
            PM_RESUME: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = PM_ACTIVE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PM_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PM_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            PM_ACTIVE: begin
                ctrl_o.sys_clk_en   = 1'b1;
                ctrl_o.prec_osc_en  = 1'b1;
                ctrl_o.lp_osc_allow = 1'b1;
                ctrl_o.core_reg_en  = 1'b1;
                ctrl_o.src_valid    = 1'b1;
            end
            PM_STOP: begin
                ctrl_o.lp_osc_allow = 1'b1;
                ctrl_o.core_reg_en  = 1'b1;
            end
            PM_SUSPEND: begin
                ctrl_o.core_reg_en  = 1'b1;
            end
            PM_SLEEP: begin
                ctrl_o.ram_main_sel = 1'b1;
                ctrl_o.wake_req_n   = 1'b1;
            end
            PM_RESUME: begin
                ctrl_o.sys_clk_en   = 1'b1;
                ctrl_o.prec_osc_en  = 1'b1;
                ctrl_o.lp_osc_allow = 1'b1;
                ctrl_o.core_reg_en  = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

    assign state_o     = state_q;
    assign lowpwr_o    = (state_q == PM_SUSPEND) || (state_q == PM_SLEEP);
    assign flag_mask_o = (state_q == PM_RESUME) && (cnt_q < CNT_MASK);

    // R3
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PM_STOP) |=> (state_q == PM_STOP));

    // R2
    mode_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PM_ACTIVE && mode_we_i && mode_code_i == MC_SUSPEND)
        |=> (state_q == PM_SUSPEND));

    // R6
    wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lowpwr_o && wake_any_i) |=> (state_q == PM_RESUME));

    // R9
    resume_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PM_RESUME && cnt_q == CNT_LAST) |=> (state_q == PM_ACTIVE));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int RESUME_CYC  = 6,
    parameter int MASK_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [DATA_W-1:0]      cfg_rdata,
    input  logic [NUM_SRC-1:0]     wake_evt,
    input  logic                   rst_pin_n,
    output logic                   sys_clk_en,
    output logic                   prec_osc_en,
    output logic                   lp_osc_en,
    output logic                   core_reg_en,
    output logic                   ram_main_sel,
    output logic                   wake_req_n,
    output logic                   src_valid
);

    logic               sys_rst_n;
    logic [NUM_SRC-1:0] evt_sync;
    logic               pin_sync;
    logic               pin_prev_q;
    logic               pin_fell;
    logic               lp_cfg_q;
    logic               wake_any;
    logic               lowpwr;
    logic               flag_mask;
    logic [NUM_SRC-1:0] en_val;
    logic [DATA_W-1:0]  flags_vis;
    pm_state_e          state;
    pm_ctrl_t           ctrl;

    assign sys_rst_n = por_n & rst_n;

    pwr_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_evt_sync (
        .clk_i (clk),
        .rst_ni(sys_rst_n),
        .d_i   (wake_evt),
        .q_o   (evt_sync)
    );

    pwr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i (clk),
        .rst_ni(sys_rst_n),
        .d_i   (rst_pin_n),
        .q_o   (pin_sync)
    );

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            pin_prev_q <= 1'b1;
        end else begin
            pin_prev_q <= pin_sync;
        end
    end

    assign pin_fell = pin_prev_q & ~pin_sync;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            lp_cfg_q <= 1'b0;
        end else if (cfg_we && cfg_addr == A_OSC) begin
            lp_cfg_q <= cfg_wdata[0];
        end
    end

    pwr_wake_flags #(.NSRC(NUM_SRC)) u_flags (
        .clk_i      (clk),
        .rst_ni     (sys_rst_n),
        .por_ni     (por_n),
        .en_we_i    (cfg_we && cfg_addr == A_WKEN),
        .clr_we_i   (cfg_we && cfg_addr == A_FLAGS),
        .wdata_i    (cfg_wdata),
        .set_en_i   (lowpwr),
        .evt_sync_i (evt_sync),
        .pin_fell_i (pin_fell),
        .mask_i     (flag_mask),
        .en_o       (en_val),
        .flags_vis_o(flags_vis),
        .wake_any_o (wake_any)
    );

    pwr_mode_fsm #(.RESUME_CYC(RESUME_CYC), .MASK_CYC(MASK_CYC)) u_fsm (
        .clk_i      (clk),
        .rst_ni     (sys_rst_n),
        .mode_we_i  (cfg_we && cfg_addr == A_MODE),
        .mode_code_i(cfg_wdata[1:0]),
        .wake_any_i (wake_any),
        .state_o    (state),
        .lowpwr_o   (lowpwr),
        .flag_mask_o(flag_mask),
        .ctrl_o     (ctrl)
    );

    always_comb begin
        unique case (cfg_addr)
            A_MODE:  cfg_rdata = DATA_W'(state);
            A_WKEN:  cfg_rdata = DATA_W'(en_val);
            A_FLAGS: cfg_rdata = flags_vis;
            default: cfg_rdata = DATA_W'(lp_cfg_q);
        endcase
    end

    assign sys_clk_en   = ctrl.sys_clk_en;
    assign prec_osc_en  = ctrl.prec_osc_en;
    assign lp_osc_en    = ctrl.lp_osc_allow & lp_cfg_q;
    assign core_reg_en  = ctrl.core_reg_en;
    assign ram_main_sel = ctrl.ram_main_sel;
    assign wake_req_n   = ctrl.wake_req_n;
    assign src_valid    = ctrl.src_valid;

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [5:0] cfg_wdata = 6'd0;
    logic [5:0] cfg_rdata;
    logic [4:0] wake_evt = 5'd0;
    logic       rst_pin_n = 1'b1;
    logic       sys_clk_en, prec_osc_en, lp_osc_en, core_reg_en;
    logic       ram_main_sel, wake_req_n, src_valid;

    int tests = 0;
    int fails = 0;

    // reference model state
    int         m_state = 0;
    int         m_cnt = 0;
    logic [4:0] m_en = 0;
    logic [5:0] m_flags = 0;
    logic       m_lp = 0;
    logic [4:0] evt_q[$];
    logic       pin_q[$];
    logic       m_pin_prev = 1'b1;

    always #2 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wake_evt(wake_evt), .rst_pin_n(rst_pin_n),
        .sys_clk_en(sys_clk_en), .prec_osc_en(prec_osc_en), .lp_osc_en(lp_osc_en),
        .core_reg_en(core_reg_en), .ram_main_sel(ram_main_sel),
        .wake_req_n(wake_req_n), .src_valid(src_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset(input logic keep_pin);
        m_state = 0; m_cnt = 0; m_en = 0; m_lp = 0;
        m_flags = keep_pin ? (m_flags & 6'h20) : 6'h00;
        evt_q = '{5'd0, 5'd0};
        pin_q = '{1'b1, 1'b1};
        m_pin_prev = 1'b1;
    endtask

    task automatic model_step();
        logic [4:0] hit;
        logic       fell, lowpwr, wake;
        logic [5:0] f;
        int         nstate, ncnt;
        if (!por_n) begin model_reset(1'b0); return; end
        if (!rst_n) begin model_reset(1'b1); return; end
        hit    = evt_q[1] & m_en;
        fell   = m_pin_prev & ~pin_q[1];
        lowpwr = (m_state == 2) || (m_state == 3);
        wake   = lowpwr && ((hit != 0) || fell);
        f = m_flags;
        if (cfg_we && cfg_addr == 2) f = f & ~cfg_wdata;
        if (lowpwr) f = f | {fell, hit};
        nstate = m_state; ncnt = m_cnt;
        if (m_state == 0 && cfg_we && cfg_addr == 0 && cfg_wdata[1:0] != 0)
            nstate = cfg_wdata[1:0];
        else if (wake) begin nstate = 4; ncnt = 0; end
        else if (m_state == 4) begin
            if (m_cnt == 5) nstate = 0; else ncnt = m_cnt + 1;
        end
        if (cfg_we && cfg_addr == 1) m_en = cfg_wdata[4:0];
        if (cfg_we && cfg_addr == 3) m_lp = cfg_wdata[0];
        m_flags = f; m_state = nstate; m_cnt = ncnt;
        m_pin_prev = pin_q[1];
        void'(pin_q.pop_back()); pin_q.push_front(rst_pin_n);
        void'(evt_q.pop_back()); evt_q.push_front(wake_evt);
    endtask

    task automatic compare();
        string r;
        int    rd_exp;
        case (m_state)
            0: r = "R1"; 1: r = "R3"; 2: r = "R4"; 3: r = "R5"; default: r = "R9";
        endcase
        chk(r, "sys_clk_en",   sys_clk_en,   (m_state == 0 || m_state == 4));
        chk(r, "prec_osc_en",  prec_osc_en,  (m_state == 0 || m_state == 4));
        chk(r, "core_reg_en",  core_reg_en,  (m_state != 3));
        chk(r, "ram_main_sel", ram_main_sel, (m_state == 3));
        chk(r, "wake_req_n",   wake_req_n,   (m_state == 3));
        chk(r, "src_valid",    src_valid,    (m_state == 0));
        chk("R12", "lp_osc_en", lp_osc_en, m_lp && (m_state == 0 || m_state == 1 || m_state == 4));
        case (cfg_addr)
            0: begin rd_exp = m_state; r = "R11"; end
            1: begin rd_exp = m_en; r = "R6"; end
            2: begin rd_exp = (m_state == 4 && m_cnt < 2) ? 0 : m_flags; r = "R8"; end
            default: begin rd_exp = m_lp; r = "R12"; end
        endcase
        chk(r, "cfg_rdata", cfg_rdata, rd_exp);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset(1'b0);
        idle(2);
        por_n = 1'b1; rst_n = 1'b1;
        idle(2);
        chk("R1", "state after por", cfg_rdata, 0);

        wr(3, 6'h01);                 // R12 low-power oscillator on
        wr(1, 6'h05);                 // R6 enable bits 0 and 2
        cfg_addr = 0;
        wr(0, 6'h00);                 // R2 code 0: no change
        chk("R2", "mode code 0 keeps run", cfg_rdata, 0);

        wr(0, 6'h02);                 // R2 enter suspend
        chk("R2", "suspend entered", cfg_rdata, 2);
        wake_evt = 5'b00010;          // R6 disabled source
        idle(6);
        chk("R6", "disabled source ignored", cfg_rdata, 2);
        wake_evt = 5'b00100;          // enabled source
        cfg_addr = 2;
        idle(12);                     // wake, resume, flags masking
        wake_evt = 5'd0;
        chk("R8", "port match flag", cfg_rdata, 6'h04);
        wr(2, 6'h04);                 // R8 W1C
        idle(1);
        chk("R8", "flag cleared", cfg_rdata, 0);

        cfg_addr = 0;
        wr(0, 6'h03);                 // R5 deep sleep
        idle(2);
        rst_pin_n = 1'b0;             // R7 short pin glitch
        idle(2);
        rst_pin_n = 1'b1;
        idle(1);
        wr(0, 6'h01);                 // R2 mode write in resume ignored
        chk("R2", "write in resume ignored", cfg_rdata, 4);
        idle(8);
        cfg_addr = 2;
        idle(1);
        chk("R7", "pin flag set", cfg_rdata, 6'h20);

        cfg_addr = 0;
        wr(0, 6'h01);                 // R3 halt
        wake_evt = 5'b00101;
        rst_pin_n = 1'b0;
        idle(6);
        rst_pin_n = 1'b1;
        wake_evt = 5'd0;
        idle(3);
        chk("R3", "halt holds", cfg_rdata, 1);

        rst_n = 1'b0;                 // R10 system reset
        idle(1);
        rst_n = 1'b1;
        cfg_addr = 2;
        idle(2);
        chk("R10", "pin flag kept", cfg_rdata, 6'h20);
        por_n = 1'b0;
        idle(1);
        por_n = 1'b1;
        idle(2);
        chk("R10", "por clears all", cfg_rdata, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule